// File: doc/BRIEF.md
# Programmable Interrupt Source Router

The router takes a bank of peripheral interrupt request lines and steers each one onto one of the seven general-purpose priority inputs of a core event controller, levels 7 through 13. Every source owns a small assignment field. The field value plus 7 names the level it drives, so software chooses both the destination and the effective priority of every source. Any number of sources may share a level. A level output is high while any source steered to it is high.

The assignment fields are packed eight to a 32-bit word, so 24 sources use three words. They are reached through a plain register port: a write strobe with an address and data, and a combinational read path. One further address returns the raw state of every source line. Out of reset the fields hold a fixed, non-uniform map. The seven error-type sources (indices 0 to 6) share level 7. The remaining sources are spread over levels 8 to 13. The level outputs are registered, so the downstream latch sees clean edges when a field is rewritten.

Top module: `irq_route_top`

## Requirements
- R1: Source n has a 4-bit field at word n/8, bits [4*(n%8)+3 : 4*(n%8)]; field value v routes the source to level 7+v. After reset, words 0, 1 and 2 read back 0x10000000, 0x33322221 and 0x66655444. This is the map: sources 0-6 to level 7, 7-8 to level 8, 9-12 to level 9, 13-15 to level 10, 16-18 to level 11, 19-20 to level 12, and 21-23 to level 13.
- R2: Output bit k (level 7+k) is high one clock edge after any source whose field equals k is high. It is low one edge after no such source is high.
- R3: Several sources assigned to one level are ORed onto that single output bit.
- R4: A field value from 7 to 15 routes its source nowhere, so that source drives no output bit.
- R5: Writing address 0, 1 or 2 with the write strobe high stores all 32 data bits into that word at the clock edge, and the same address reads them back.
- R6: A reassignment written at edge t changes the outputs from edge t+1. The outputs sampled after edge t still follow the old map.
- R7: While a field is being rewritten, an output bit whose contributing sources are unchanged holds its value through the write.
- R8: Address 3 reads the raw source lines in bits 23:0, with zeros above them. A write to address 3 changes no stored field.
- R9: While reset is asserted (active low), all level outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 24 | Raw peripheral interrupt lines |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0-2 assignment words, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| lvl_irq | output | 7 | Routed requests, bit k drives level 7+k |

## Verification
A source change is due on the level outputs one edge later. A field write is due on the outputs two edges after it is issued: the first edge stores the field and the second re-registers the OR. Read data is combinational and is due in the same cycle as the address. The bench drives inputs on the falling edge. It samples one falling edge after each rising edge and checks the old map at the first sample after a write and the new map at the second.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Level offset (field value) each source takes out of reset.
  function automatic logic [3:0] reset_field(input int n);
    if (n < 7)       return 4'd0;
    else if (n < 9)  return 4'd1;
    else if (n < 13) return 4'd2;
    else if (n < 16) return 4'd3;
    else if (n < 19) return 4'd4;
    else if (n < 21) return 4'd5;
    else             return 4'd6;
  endfunction

endpackage

// File: rtl/irq_assign_regs.sv
module irq_assign_regs #(
  parameter int NUM_SRC = 24,
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  localparam int PER_WORD = DATA_W / FIELD_W,
  localparam int NUM_WORD = (NUM_SRC + PER_WORD - 1) / PER_WORD
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wen,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_WORD*DATA_W-1:0]  words,
  output logic [NUM_SRC*FIELD_W-1:0]  fields
);
  import irq_route_pkg::*;

  logic [DATA_W-1:0] word_q [NUM_WORD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORD; w++) begin
        word_q[w] <= '0;
        for (int f = 0; f < PER_WORD; f++) begin
          if (w * PER_WORD + f < NUM_SRC)
            word_q[w][f*FIELD_W +: FIELD_W] <= FIELD_W'(reset_field(w * PER_WORD + f));
        end
      end
    end else if (wen && (32'(waddr) < NUM_WORD)) begin
      word_q[waddr] <= wdata;
    end
  end

  for (genvar w = 0; w < NUM_WORD; w++) begin : g_word
    assign words[w*DATA_W +: DATA_W] = word_q[w];

    assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && (32'(waddr) == w)) |=> (word_q[w] == $past(wdata)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wen && (32'(waddr) == w)) |=> $stable(word_q[w]));
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_field
    assign fields[n*FIELD_W +: FIELD_W] =
      word_q[n / PER_WORD][(n % PER_WORD)*FIELD_W +: FIELD_W];
  end

endmodule

// File: rtl/irq_level_or.sv
module irq_level_or #(
  parameter int NUM_SRC = 24,
  parameter int FIELD_W = 4,
  parameter int NUM_LVL = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src,
  input  logic [NUM_SRC*FIELD_W-1:0] fields,
  output logic [NUM_LVL-1:0]         lvl_q
);

  logic [NUM_LVL-1:0] hit;

  always_comb begin
    hit = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (src[n] && (fields[n*FIELD_W +: FIELD_W] == FIELD_W'(k)))
          hit[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= hit;
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
      assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src[n] && (fields[n*FIELD_W +: FIELD_W] == FIELD_W'(k))) |=> lvl_q[k]);
    end
  end

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src) == '0) |-> (lvl_q == '0));

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int NUM_SRC = 24,
  parameter int FIELD_W = 4,
  parameter int NUM_LVL = 7,
  parameter int DATA_W  = 32,
  localparam int PER_WORD = DATA_W / FIELD_W,
  localparam int NUM_WORD = (NUM_SRC + PER_WORD - 1) / PER_WORD,
  localparam int ADDR_W   = $clog2(NUM_WORD + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               reg_wen,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_LVL-1:0] lvl_irq
);

  logic [NUM_WORD*DATA_W-1:0] words;
  logic [NUM_SRC*FIELD_W-1:0] fields;

  irq_assign_regs #(
    .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .waddr(reg_addr),
    .wdata(reg_wdata), .words(words), .fields(fields)
  );

  irq_level_or #(
    .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .NUM_LVL(NUM_LVL)
  ) u_or (
    .clk(clk), .rst_n(rst_n), .src(src_irq), .fields(fields), .lvl_q(lvl_irq)
  );

  // Read path: assignment words below NUM_WORD, raw source status at NUM_WORD.
  always_comb begin
    reg_rdata = '0;
    if (32'(reg_addr) < NUM_WORD)
      reg_rdata = words[reg_addr*DATA_W +: DATA_W];
    else if (32'(reg_addr) == NUM_WORD)
      reg_rdata = DATA_W'(src_irq);
  end

  assert_reset_low_R9: assert property (@(posedge clk)
    !rst_n |=> (lvl_irq == '0));

  assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(reg_addr) == NUM_WORD) |-> (reg_rdata == DATA_W'(src_irq)));

endmodule

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src_irq = '0;
  logic        reg_wen = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  lvl_irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_route_top u0 (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_irq(lvl_irq)
  );

  // {sources, expected levels} under the reset map
  localparam logic [30:0] VEC [11] = '{
    {24'h000000, 7'h00}, {24'h000001, 7'h01}, {24'h000080, 7'h02},
    {24'h001000, 7'h04}, {24'h008000, 7'h08}, {24'h040000, 7'h10},
    {24'h100000, 7'h20}, {24'h800000, 7'h40}, {24'hFFFFFF, 7'h7F},
    {24'h000041, 7'h01}, {24'h202000, 7'h48}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    step();
    reg_wen = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    src_irq = 24'hFFFFFF;
    step(); step();
    chk("R9 outputs low in reset", 32'(lvl_irq), 32'h0);
    src_irq = '0;
    rst_n = 1'b1;
    step();
    rd_chk("R1 word0 default", 2'd0, 32'h10000000);
    rd_chk("R1 word1 default", 2'd1, 32'h33322221);
    rd_chk("R1 word2 default", 2'd2, 32'h66655444);

    // R2 R3: default-map routing table
    for (int i = 0; i < 11; i++) begin
      src_irq = VEC[i][30:7];
      step();
      chk("R2/R3 routed levels", 32'(lvl_irq), 32'(VEC[i][6:0]));
      rd_chk("R8 status", 2'd3, 32'(VEC[i][30:7]));
    end

    // R6 R7: move source 0 from level 7 to level 13 while source 7 holds level 8
    src_irq = 24'h000081;
    step();
    chk("R2 before write", 32'(lvl_irq), 32'h03);
    wr(2'd0, 32'h10000006);
    chk("R6 old map after write edge", 32'(lvl_irq), 32'h03);
    chk("R7 level8 held during write", 32'(lvl_irq[1]), 32'h1);
    step();
    chk("R6 new map next edge", 32'(lvl_irq), 32'h42);
    rd_chk("R5 readback word0", 2'd0, 32'h10000006);

    // R4: unrouted field values
    wr(2'd0, 32'h1000000F);
    step();
    chk("R4 field 15 unrouted", 32'(lvl_irq), 32'h02);
    wr(2'd0, 32'h10000007);
    step();
    chk("R4 field 7 unrouted", 32'(lvl_irq), 32'h02);

    // R5: full-word write to word2, all sources there to level 7
    wr(2'd2, 32'h00000000);
    rd_chk("R5 readback word2", 2'd2, 32'h00000000);
    src_irq = 24'h810000;
    step();
    chk("R3 sources 16,23 on level7", 32'(lvl_irq), 32'h01);

    // R8: write to status address changes nothing
    wr(2'd3, 32'hFFFFFFFF);
    rd_chk("R8 word0 unchanged", 2'd0, 32'h10000007);
    rd_chk("R8 word1 unchanged", 2'd1, 32'h33322221);
    rd_chk("R8 word2 unchanged", 2'd2, 32'h00000000);
    rd_chk("R8 status after write", 2'd3, 32'h00810000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule